// File: doc/BRIEF.md
# Receive Descriptor Ring Index Tracker

This block sits on the device side of a single receive descriptor ring that lives in host memory. The host publishes how far it has restocked the ring by writing a producer index. The block keeps its own fill index and hands out descriptor slots one at a time to incoming frames through a request/grant handshake. Each descriptor stands for exactly one receive buffer. When a granted buffer is closed, the block publishes the index of that descriptor in a 32-bit status word and pulses an interrupt.

The ring holds a power-of-two number of entries, set by a 4-bit log2 field and 256 after reset. Both indices wrap to zero at the end of the ring. The slot the host index points at is never handed out, because an equal fill index and host index mean the ring has no free buffer. For that reason one slot always stays empty. Host index updates must be multiples of 8 and must fall inside the ring. A write that breaks either rule is refused and flagged.

Top module: `rx_ring_tracker`

## Requirements
- R1: A synchronous reset clears the fill index, the close index and the host index to zero. It sets the ring size to 256 entries (log2 = 8) and drives `gnt`, `irq`, `wr_err` and `status_word` to zero. Just after reset, no grant is made.
- R2: While `chan_en` is high, `req` is high and the ring has room, `gnt` is high one cycle later. `gnt_idx` then carries the fill index, and the fill index steps by one. With `req` held high, the grants carry consecutive indices.
- R3: When the fill index equals the host index, no grant is made and arrivals stall. Starting from fill index F, a host index of H yields exactly (H−F) mod depth grants.
- R4: A host index write (`wr_valid`) whose low 3 bits are not zero, or whose value is not below the ring depth, raises `wr_err` for one cycle after the write. It leaves the host index unchanged. A legal write updates the host index and leaves `wr_err` low.
- R5: The fill index wraps from depth−1 to 0.
- R6: A `close` while granted buffers are still open loads bits 11:0 of `status_word` with the index of the oldest open buffer, one cycle later. Bits 31:12 of `status_word` are always zero.
- R7: Each status update drives `irq` high for exactly that one cycle, unless `irq_mask` was high with the `close`. In that case `irq` stays low.
- R8: `cfg_log2` is taken as the ring size only while `chan_en` is low. Values below 4 are taken as 4, and values above 12 as 12. A change while `chan_en` is high has no effect.
- R9: A `close` with no open granted buffer leaves `status_word` unchanged and raises no `irq`.
- R10: While `chan_en` is low, `req` produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; the size can be configured only while it is low |
| cfg_log2 | input | 4 | Requested log2 of the ring depth |
| irq_mask | input | 1 | Suppresses the interrupt pulse |
| wr_valid | input | 1 | Host index write strobe |
| wr_index | input | 12 | Host index value |
| req | input | 1 | A frame needs a buffer |
| close | input | 1 | The oldest open buffer has been filled |
| gnt | output | 1 | A descriptor is granted this cycle |
| gnt_idx | output | 12 | Index of the granted descriptor |
| status_word | output | 32 | Last filled descriptor index in bits 11:0 |
| irq | output | 1 | One-cycle interrupt on each status update |
| wr_err | output | 1 | One-cycle flag for a refused host write |

## Verification
Every result is one register stage behind its cause. `gnt` and `gnt_idx` follow the cycle in which `req` is sampled. `status_word` and `irq` follow `close`. `wr_err` follows `wr_valid`. A legal host write first affects grants one cycle after it is taken. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so every check reads exactly the rising edge that consumed its stimulus. Grant counts are taken by sampling once per cycle over a fixed window while `req` is held. This shows both the stall at the host index and the exact number of grants.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int LOG_W  = 4;
  localparam int STAT_W = 32;

  function automatic logic [LOG_W-1:0] clamp_log(input logic [LOG_W-1:0] v,
                                                 input int lo, input int hi);
    if (int'(v) < lo) return LOG_W'(lo);
    if (int'(v) > hi) return LOG_W'(hi);
    return v;
  endfunction
endpackage

// File: rtl/rx_ring_cfg.sv
module rx_ring_cfg
  import rx_ring_pkg::*;
#(
  parameter int MIN_LOG2 = 4,
  parameter int MAX_LOG2 = 12,
  parameter int DEF_LOG2 = 8,
  parameter int IDX_W    = MAX_LOG2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic [LOG_W-1:0] cfg_log2,
  output logic [IDX_W-1:0] idx_mask
);
  logic [LOG_W-1:0] size_log2;
  logic [IDX_W:0]   span;

  always_ff @(posedge clk) begin
    if (rst)          size_log2 <= LOG_W'(DEF_LOG2);
    else if (!chan_en) size_log2 <= clamp_log(cfg_log2, MIN_LOG2, MAX_LOG2);
  end

  always_comb begin
    span     = (IDX_W+1)'(1) << size_log2;
    idx_mask = IDX_W'(span - (IDX_W+1)'(1));
  end

  // R8: size moves only when the channel was disabled
  p_size_hold_r8: assert property (@(posedge clk) disable iff (rst)
    $past(chan_en) |-> $stable(size_log2));
  // R8: size stays inside the clamped range
  p_size_range_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(size_log2) >= MIN_LOG2) && (int'(size_log2) <= MAX_LOG2));
endmodule

// File: rtl/rx_host_index.sv
module rx_host_index #(
  parameter int IDX_W    = 12,
  parameter int STEP_LOG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_index,
  input  logic [IDX_W-1:0] idx_mask,
  output logic [IDX_W-1:0] host_idx,
  output logic             wr_err
);
  logic misaligned, beyond;

  always_comb begin
    misaligned = |wr_index[STEP_LOG-1:0];
    beyond     = |(wr_index & ~idx_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_idx <= '0;
      wr_err   <= 1'b0;
    end else begin
      wr_err <= wr_valid && (misaligned || beyond);
      if (wr_valid && !misaligned && !beyond) host_idx <= wr_index;
    end
  end

  // R4: a refused write never moves the host index
  p_err_no_move_r4: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $stable(host_idx));
  // R4: the stored index is always step aligned
  p_host_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    host_idx[STEP_LOG-1:0] == '0);
endmodule

// File: rtl/rx_fill_ctrl.sv
module rx_fill_ctrl #(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             irq_mask,
  input  logic             req,
  input  logic             close,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [IDX_W-1:0] idx_mask,
  output logic             gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic [IDX_W-1:0] status_idx,
  output logic             irq
);
  logic [IDX_W-1:0] fill_ptr, cls_ptr;
  logic room, take, open_bufs, do_close;

  always_comb begin
    room      = fill_ptr != host_idx;
    take      = req && chan_en && room;
    open_bufs = cls_ptr != fill_ptr;
    do_close  = close && open_bufs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_ptr <= '0;
      gnt      <= 1'b0;
      gnt_idx  <= '0;
    end else begin
      gnt <= take;
      if (take) begin
        gnt_idx  <= fill_ptr;
        fill_ptr <= (fill_ptr + IDX_W'(1)) & idx_mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_ptr    <= '0;
      status_idx <= '0;
      irq        <= 1'b0;
    end else begin
      irq <= do_close && !irq_mask;
      if (do_close) begin
        status_idx <= cls_ptr;
        cls_ptr    <= (cls_ptr + IDX_W'(1)) & idx_mask;
      end
    end
  end

  // R2, R10: a grant needs an enabled request in the prior cycle
  p_grant_cause_r10: assert property (@(posedge clk) disable iff (rst)
    gnt |-> $past(req && chan_en));
  // R3: the slot at the host index is never granted
  p_no_grant_full_r3: assert property (@(posedge clk) disable iff (rst)
    gnt |-> (gnt_idx != $past(host_idx)));
  // R6: status changes only after a close
  p_status_cause_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_idx) |-> $past(close));
  // R7: no interrupt while masked
  p_irq_unmasked_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(close && !irq_mask));
endmodule

// File: rtl/rx_ring_tracker.sv
module rx_ring_tracker
  import rx_ring_pkg::*;
#(
  parameter int MIN_LOG2 = 4,
  parameter int MAX_LOG2 = 12,
  parameter int DEF_LOG2 = 8,
  parameter int STEP_LOG = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  chan_en,
  input  logic [LOG_W-1:0]      cfg_log2,
  input  logic                  irq_mask,
  input  logic                  wr_valid,
  input  logic [MAX_LOG2-1:0]   wr_index,
  input  logic                  req,
  input  logic                  close,
  output logic                  gnt,
  output logic [MAX_LOG2-1:0]   gnt_idx,
  output logic [STAT_W-1:0]     status_word,
  output logic                  irq,
  output logic                  wr_err
);
  localparam int IDX_W = MAX_LOG2;

  logic [IDX_W-1:0] idx_mask, host_idx, status_idx;

  rx_ring_cfg #(.MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2), .DEF_LOG2(DEF_LOG2),
                .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .chan_en(chan_en), .cfg_log2(cfg_log2),
    .idx_mask(idx_mask)
  );

  rx_host_index #(.IDX_W(IDX_W), .STEP_LOG(STEP_LOG)) u_host (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_index(wr_index),
    .idx_mask(idx_mask), .host_idx(host_idx), .wr_err(wr_err)
  );

  rx_fill_ctrl #(.IDX_W(IDX_W)) u_fill (
    .clk(clk), .rst(rst), .chan_en(chan_en), .irq_mask(irq_mask),
    .req(req), .close(close), .host_idx(host_idx), .idx_mask(idx_mask),
    .gnt(gnt), .gnt_idx(gnt_idx), .status_idx(status_idx), .irq(irq)
  );

  assign status_word = STAT_W'(status_idx);

  // R6: upper status bits stay clear
  p_status_upper_r6: assert property (@(posedge clk) disable iff (rst)
    status_word[STAT_W-1:12] == '0);
endmodule

// File: tb/sim_rx_ring_tracker.sv
module sim_rx_ring_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_en = 1'b0, irq_mask = 1'b0, wr_valid = 1'b0, req = 1'b0, close = 1'b0;
  logic [3:0]  cfg_log2 = 4'd8;
  logic [11:0] wr_index = '0;
  logic        gnt, irq, wr_err;
  logic [11:0] gnt_idx;
  logic [31:0] status_word;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rx_ring_tracker u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .cfg_log2(cfg_log2),
    .irq_mask(irq_mask), .wr_valid(wr_valid), .wr_index(wr_index),
    .req(req), .close(close), .gnt(gnt), .gnt_idx(gnt_idx),
    .status_word(status_word), .irq(irq), .wr_err(wr_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; chan_en = 1'b0; req = 1'b0; close = 1'b0;
    wr_valid = 1'b0; irq_mask = 1'b0; cfg_log2 = 4'd8;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_write(input int idx, output bit err);
    wr_valid = 1'b1; wr_index = 12'(idx);
    @(negedge clk);
    err = wr_err;
    wr_valid = 1'b0;
  endtask

  task automatic run_req(input int n, input int first_exp, output int cnt,
                         output bit seq_ok);
    int expi = first_exp;
    cnt = 0; seq_ok = 1'b1;
    req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gnt) begin
        if (int'(gnt_idx) != expi) seq_ok = 1'b0;
        expi = (expi + 1) % 4096;
        cnt++;
      end
    end
    req = 1'b0;
  endtask

  task automatic do_close(input bit masked);
    irq_mask = masked; close = 1'b1;
    @(negedge clk);
    close = 1'b0; irq_mask = 1'b0;
  endtask

  task automatic t_reset();
    int c; bit s, e;
    do_reset();
    chk(!gnt && !irq && !wr_err, "R1 outputs idle", int'(gnt), 0);
    chk(status_word == 32'd0, "R1 status zero", int'(status_word), 0);
    chan_en = 1'b1;
    run_req(4, 0, c, s);
    chk(c == 0, "R1 no grant after reset", c, 0);
    host_write(248, e);
    chk(!e, "R1 depth 256 accepts 248", int'(e), 0);
  endtask

  task automatic t_grants();
    int c; bit s, e;
    do_reset();
    host_write(16, e);
    run_req(6, 0, c, s);
    chk(c == 0, "R10 no grant when disabled", c, 0);
    chan_en = 1'b1;
    host_write(8, e);
    chk(!e, "R4 legal write no error", int'(e), 0);
    run_req(12, 0, c, s);
    chk(c == 8, "R3 grants stop at host index", c, 8);
    chk(s, "R2 consecutive grant indices", int'(s), 1);
    host_write(16, e);
    run_req(3, 8, c, s);
    chk(c == 3 && s, "R2 grants resume at 8", c, 3);
  endtask

  task automatic t_bad_write();
    int c; bit s, e;
    do_reset();
    chan_en = 1'b1;
    host_write(8, e);
    host_write(13, e);
    chk(e, "R4 misaligned write flagged", int'(e), 1);
    @(negedge clk);
    chk(!wr_err, "R4 error is one cycle", int'(wr_err), 0);
    run_req(14, 0, c, s);
    chk(c == 8, "R4 host index unchanged", c, 8);
  endtask

  task automatic t_wrap();
    int c; bit s, e;
    do_reset();
    cfg_log2 = 4'd4;
    @(negedge clk);
    chan_en = 1'b1;
    host_write(16, e);
    chk(e, "R4 index at depth flagged", int'(e), 1);
    host_write(8, e);
    run_req(10, 0, c, s);
    chk(c == 8 && s, "R5 first half of ring", c, 8);
    host_write(0, e);
    run_req(10, 8, c, s);
    chk(c == 8 && s, "R5 grants 8..15 then stall", c, 8);
    host_write(8, e);
    run_req(1, 0, c, s);
    chk(c == 1 && s, "R5 fill index wrapped to 0", int'(gnt_idx), 0);
  endtask

  task automatic t_status();
    int c; bit s, e;
    do_reset();
    chan_en = 1'b1;
    host_write(8, e);
    run_req(3, 0, c, s);
    do_close(1'b0);
    chk(status_word == 32'd0 && irq, "R7 irq on first close", int'(irq), 1);
    @(negedge clk);
    chk(!irq, "R7 irq lasts one cycle", int'(irq), 0);
    close = 1'b1;
    @(negedge clk);
    chk(status_word == 32'd1 && irq, "R6 status 1", int'(status_word), 1);
    @(negedge clk);
    close = 1'b0;
    chk(status_word == 32'd2 && irq, "R6 status 2", int'(status_word), 2);
    do_close(1'b0);
    chk(status_word == 32'd2 && !irq, "R9 close ignored when none open",
        int'(status_word), 2);
    run_req(1, 3, c, s);
    do_close(1'b1);
    chk(status_word == 32'd3, "R6 full word zero upper", int'(status_word), 3);
    chk(!irq, "R7 masked close no irq", int'(irq), 0);
  endtask

  task automatic t_config();
    bit e;
    do_reset();
    chan_en = 1'b1; cfg_log2 = 4'd4;
    @(negedge clk);
    host_write(64, e);
    chk(!e, "R8 size change while enabled ignored", int'(e), 0);
    chan_en = 1'b0;
    @(negedge clk);
    host_write(64, e);
    chk(e, "R8 size 16 taken while disabled", int'(e), 1);
    cfg_log2 = 4'd15;
    @(negedge clk);
    host_write(2048, e);
    chk(!e, "R8 clamp high to 4096", int'(e), 0);
    cfg_log2 = 4'd0;
    @(negedge clk);
    host_write(8, e);
    chk(!e, "R8 clamp low allows 8", int'(e), 0);
    host_write(16, e);
    chk(e, "R8 clamp low gives depth 16", int'(e), 1);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_grants();
    t_bad_write();
    t_wrap();
    t_status();
    t_config();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule